// File: doc/BRIEF.md
# Receive Station-Address Filter with Loadable Match Table

This block decides whether an incoming frame is meant for this station, based on its 48-bit destination address. It keeps a table of sixteen station addresses, each enabled or disabled by one bit of a 16-bit mask. It also applies three address-class overrides: pass-all-individual, pass-all-group and pass-broadcast. These overrides are evaluated before the table lookup. The decision and a two-flag class indication are combinational from the presented address, the mode inputs and the stored table.

The table is filled from system memory. A load command latches a 16-bit upper segment, a 16-bit descriptor pointer and a descriptor count. A sequencer then walks the descriptors one word read at a time over a request/valid port. Each descriptor occupies four 16-bit fields, and its last three fields carry the address. After the final descriptor, the first field of the following descriptor holds the enable mask. A sticky completion flag then rises. While the surrounding controller is in reset mode, any table entry can be read back as three 16-bit words.

Top module: `rx_cam_filter`

## Requirements
- R1: An address equal in all 48 bits to a table entry whose mask bit is 1 is accepted with both class flags low. An entry whose mask bit is 0 never causes acceptance.
- R2: Descriptor fields 1, 2 and 3 hold address bytes 0-1, 2-3 and 4-5 respectively, the lower byte of each field being the earlier address byte. Byte 0 sits at `dstAddr[7:0]` and byte 5 at `dstAddr[47:40]`. Field 0 of a loaded descriptor is never read.
- R3: The byte offset of field k is 2k when `wideBus`=0 and 4k when `wideBus`=1. The descriptor size is 8 or 16 bytes correspondingly. `wideBus` is sampled with the load command.
- R4: Descriptors are processed while the low 5 bits of the count are nonzero, each one decrementing the count. Descriptor i goes to entry i modulo 16. A count whose low 5 bits are zero (e.g. 0x0020) loads no entry.
- R5: After the last descriptor, field 0 at the current pointer is read as the enable mask. `loadDone` is then set, `loadBusy` falls in the same cycle, and `loadDone` stays set until a `doneClr` pulse.
- R6: With `modePromisc`=1, any address whose byte 0 bit 0 is 0 is accepted with both class flags low; this rule has top priority.
- R7: With `modeAllMulti`=1, any address whose byte 0 bit 0 is 1 is accepted with `isMcast`=1. This applies to the all-ones address too, which then reports `isMcast`, not `isBcast`.
- R8: With `modeBcast`=1 the all-ones address is accepted with `isBcast`=1, unless R7 applied first.
- R9: An address accepted by none of R1, R6, R7, R8 gives `accept`=0 and both flags 0.
- R10: With `rstMode`=1, `rdWord` returns field `wordSel`+1 of entry `entrySel` as it was loaded (wordSel 0..2). With `rstMode`=0 or `wordSel`=3, `rdWord` is 0.
- R11: The read address is `{segment, pointer + field offset}`. At most one read is outstanding, and `memReq` and `memAddr` hold steady until a cycle with `memValid`=1.
- R12: A load command arriving while `loadBusy`=1 is ignored: the running load completes with its own parameters and issues no extra reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadCmd | input | 1 | Start a table load (one-cycle pulse) |
| wideBus | input | 1 | 1 = 32-bit field stride, 0 = 16-bit |
| segBase | input | 16 | Upper 16 bits of every load address |
| descPtr | input | 16 | First descriptor byte pointer |
| descCnt | input | 16 | Descriptor count (low 5 bits used) |
| memReq | output | 1 | Word read request |
| memAddr | output | 32 | Byte address of the requested word |
| memValid | input | 1 | Read data valid; completes the request |
| memRdata | input | 16 | Read data |
| loadBusy | output | 1 | Load sequence in progress |
| loadDone | output | 1 | Sticky load-complete flag |
| doneClr | input | 1 | Clears `loadDone` |
| dstAddr | input | 48 | Destination address, byte 0 in bits 7:0 |
| modePromisc | input | 1 | Accept all individual addresses |
| modeAllMulti | input | 1 | Accept all group addresses |
| modeBcast | input | 1 | Accept the broadcast address |
| accept | output | 1 | Frame accepted |
| isBcast | output | 1 | Accepted as broadcast |
| isMcast | output | 1 | Accepted as group |
| rstMode | input | 1 | Readback enable (reset mode) |
| entrySel | input | 4 | Entry selected for readback |
| wordSel | input | 2 | Field selected for readback |
| rdWord | output | 16 | Readback data |

## Verification
The hardest situations to reach are a count above sixteen, where descriptor 16 onwards overwrites early entries, and a second load command landing mid-sequence. Both are driven deliberately: one load uses count 0x13, and another fires a conflicting command while the responder is stalling. The memory responder varies its latency per request and logs every address. Each log is compared against the stride arithmetic for narrow and wide modes. After each load, every entry is read back, and each entry address plus class patterns is swept through all eight override combinations against a bench-side priority model.

// File: rtl/rx_cam_pkg.sv
package rx_cam_pkg;
  parameter int NUM_ENTRIES    = 16;
  parameter int ENTRY_IDX_W    = $clog2(NUM_ENTRIES);
  parameter int WORD_W         = 16;
  parameter int ADDR_BYTES     = 6;
  parameter int MAC_W          = 8 * ADDR_BYTES;
  parameter int FIELDS_PER_ENT = MAC_W / WORD_W;
  parameter int DESC_FIELDS    = 4;
  parameter int CNT_LOOP_W     = 5;

  typedef struct packed {
    logic                   wrEn;
    logic [1:0]             wrField;
    logic [ENTRY_IDX_W-1:0] wrEntry;
    logic                   maskWr;
  } camStrobe_t;

  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_FETCH = 2'd1,
    LD_MASK  = 2'd2
  } ldState_t;
endpackage

// File: rtl/rx_cam_ctrl.sv
module rx_cam_ctrl
  import rx_cam_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                loadCmd,
  input  logic                wideBus,
  input  logic [WORD_W-1:0]   segBase,
  input  logic [WORD_W-1:0]   descPtr,
  input  logic [WORD_W-1:0]   descCnt,
  input  logic                memValid,
  input  logic                doneClr,
  output logic                memReq,
  output logic [2*WORD_W-1:0] memAddr,
  output logic                loadBusy,
  output logic                loadDone,
  output camStrobe_t          strobe
);
  localparam int FIELD_BYTES = WORD_W / 8;

  ldState_t               stateR;
  logic [WORD_W-1:0]      segR, ptrR, cntR;
  logic                   wideR;
  logic [ENTRY_IDX_W-1:0] entryR;
  logic [1:0]             fieldR;
  logic                   doneR;

  logic [WORD_W-1:0] fieldOff, descBytes, cntNext;

  // field offset doubles in wide mode, as does the descriptor size
  always_comb begin
    fieldOff  = wideR ? WORD_W'(fieldR) * WORD_W'(2 * FIELD_BYTES)
                      : WORD_W'(fieldR) * WORD_W'(FIELD_BYTES);
    descBytes = wideR ? WORD_W'(2 * FIELD_BYTES * DESC_FIELDS)
                      : WORD_W'(FIELD_BYTES * DESC_FIELDS);
    cntNext   = cntR - WORD_W'(1);
  end

  assign memReq   = (stateR != LD_IDLE);
  assign memAddr  = {segR, ptrR + ((stateR == LD_FETCH) ? fieldOff : '0)};
  assign loadBusy = (stateR != LD_IDLE);
  assign loadDone = doneR;

  always_comb begin
    strobe.wrEn    = (stateR == LD_FETCH) && memValid;
    strobe.wrField = fieldR;
    strobe.wrEntry = entryR;
    strobe.maskWr  = (stateR == LD_MASK) && memValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateR <= LD_IDLE;
      segR   <= '0;
      ptrR   <= '0;
      cntR   <= '0;
      wideR  <= 1'b0;
      entryR <= '0;
      fieldR <= 2'd1;
    end else begin
      case (stateR)
        LD_IDLE: begin
          if (loadCmd) begin
            segR   <= segBase;
            ptrR   <= descPtr;
            cntR   <= descCnt;
            wideR  <= wideBus;
            entryR <= '0;
            fieldR <= 2'd1;
            stateR <= (descCnt[CNT_LOOP_W-1:0] != '0) ? LD_FETCH : LD_MASK;
          end
        end
        LD_FETCH: begin
          if (memValid) begin
            if (fieldR == 2'(FIELDS_PER_ENT)) begin
              fieldR <= 2'd1;
              entryR <= entryR + 1'b1;
              cntR   <= cntNext;
              ptrR   <= ptrR + descBytes;
              if (cntNext[CNT_LOOP_W-1:0] == '0) stateR <= LD_MASK;
            end else begin
              fieldR <= fieldR + 2'd1;
            end
          end
        end
        LD_MASK: begin
          if (memValid) stateR <= LD_IDLE;
        end
        default: stateR <= LD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                doneR <= 1'b0;
    else if ((stateR == LD_MASK) && memValid) doneR <= 1'b1;
    else if (doneClr)                         doneR <= 1'b0;
  end
endmodule

// File: rtl/rx_cam_dp.sv
module rx_cam_dp
  import rx_cam_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  camStrobe_t             strobe,
  input  logic [WORD_W-1:0]      wrData,
  input  logic [MAC_W-1:0]       dstAddr,
  input  logic                   modePromisc,
  input  logic                   modeAllMulti,
  input  logic                   modeBcast,
  input  logic                   rstMode,
  input  logic [ENTRY_IDX_W-1:0] entrySel,
  input  logic [1:0]             wordSel,
  output logic                   accept,
  output logic                   isBcast,
  output logic                   isMcast,
  output logic [WORD_W-1:0]      rdWord
);
  logic [MAC_W-1:0]       tbl [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] enMask;
  logic [NUM_ENTRIES-1:0] hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < NUM_ENTRIES; e++) tbl[e] <= '0;
      enMask <= '0;
    end else begin
      if (strobe.wrEn) begin
        case (strobe.wrField)
          2'd1: tbl[strobe.wrEntry][0*WORD_W +: WORD_W] <= wrData;
          2'd2: tbl[strobe.wrEntry][1*WORD_W +: WORD_W] <= wrData;
          2'd3: tbl[strobe.wrEntry][2*WORD_W +: WORD_W] <= wrData;
          default: ;
        endcase
      end
      if (strobe.maskWr) enMask <= wrData[NUM_ENTRIES-1:0];
    end
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_match
    assign hitVec[g] = enMask[g] && (tbl[g] == dstAddr);
  end

  logic groupBit, promiscHit, multiHit, bcastHit, camHit;

  always_comb begin
    groupBit   = dstAddr[0];
    promiscHit = modePromisc && !groupBit;
    multiHit   = modeAllMulti && groupBit;
    bcastHit   = modeBcast && (&dstAddr);
    camHit     = |hitVec;
    accept     = promiscHit || multiHit || bcastHit || camHit;
    isMcast    = !promiscHit && multiHit;
    isBcast    = !promiscHit && !multiHit && bcastHit;
  end

  always_comb begin
    rdWord = '0;
    if (rstMode && (wordSel < 2'(FIELDS_PER_ENT)))
      rdWord = tbl[entrySel][32'(wordSel) * WORD_W +: WORD_W];
  end
endmodule

// File: rtl/rx_cam_filter.sv
module rx_cam_filter
  import rx_cam_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   loadCmd,
  input  logic                   wideBus,
  input  logic [WORD_W-1:0]      segBase,
  input  logic [WORD_W-1:0]      descPtr,
  input  logic [WORD_W-1:0]      descCnt,
  output logic                   memReq,
  output logic [2*WORD_W-1:0]    memAddr,
  input  logic                   memValid,
  input  logic [WORD_W-1:0]      memRdata,
  output logic                   loadBusy,
  output logic                   loadDone,
  input  logic                   doneClr,
  input  logic [MAC_W-1:0]       dstAddr,
  input  logic                   modePromisc,
  input  logic                   modeAllMulti,
  input  logic                   modeBcast,
  output logic                   accept,
  output logic                   isBcast,
  output logic                   isMcast,
  input  logic                   rstMode,
  input  logic [ENTRY_IDX_W-1:0] entrySel,
  input  logic [1:0]             wordSel,
  output logic [WORD_W-1:0]      rdWord
);
  camStrobe_t strobe;

  rx_cam_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .loadCmd(loadCmd), .wideBus(wideBus),
    .segBase(segBase), .descPtr(descPtr), .descCnt(descCnt),
    .memValid(memValid), .doneClr(doneClr), .memReq(memReq),
    .memAddr(memAddr), .loadBusy(loadBusy), .loadDone(loadDone),
    .strobe(strobe)
  );

  rx_cam_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(memRdata),
    .dstAddr(dstAddr), .modePromisc(modePromisc), .modeAllMulti(modeAllMulti),
    .modeBcast(modeBcast), .rstMode(rstMode), .entrySel(entrySel),
    .wordSel(wordSel), .accept(accept), .isBcast(isBcast),
    .isMcast(isMcast), .rdWord(rdWord)
  );
endmodule

// File: rtl/rx_cam_filter_chk.sv
module rx_cam_filter_chk (
  input logic        clk,
  input logic        rstN,
  input logic        loadCmd,
  input logic        loadBusy,
  input logic        loadDone,
  input logic        doneClr,
  input logic        memReq,
  input logic        memValid,
  input logic [31:0] memAddr,
  input logic        rstMode,
  input logic [15:0] rdWord,
  input logic        accept,
  input logic        isBcast,
  input logic        isMcast
);
  // R11: a pending read keeps its request and address until data returns
  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr));

  // R12: a command during a load neither ends nor redirects it
  p_cmd_ignored_r12: assert property (@(posedge clk) disable iff (!rstN)
    loadBusy && loadCmd && !memValid |=> loadBusy && $stable(memAddr));

  // R5: completion flag rises exactly as the sequence finishes
  p_done_at_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadDone) |-> $past(loadBusy) && !loadBusy);

  // R5: clear pulse drops the flag when no completion coincides
  p_done_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneClr && !(loadBusy && memValid) |=> !loadDone);

  // R10: readback is gated by reset mode
  p_readback_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rstMode |-> rdWord == 16'h0000);

  // R7/R8: class flags are exclusive and imply acceptance
  p_flags_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (isBcast || isMcast) |-> accept && !(isBcast && isMcast));
endmodule

bind rx_cam_filter rx_cam_filter_chk u_chk (.*);

// File: tb/rx_cam_filter_tb.sv
module rx_cam_filter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadCmd = 1'b0, wideBus = 1'b0, doneClr = 1'b0;
  logic [15:0] segBase = '0, descPtr = '0, descCnt = '0;
  logic        memReq, memValid = 1'b0;
  logic [31:0] memAddr;
  logic [15:0] memRdata = '0;
  logic        loadBusy, loadDone;
  logic [47:0] dstAddr = '0;
  logic        modePromisc = 1'b0, modeAllMulti = 1'b0, modeBcast = 1'b0;
  logic        accept, isBcast, isMcast;
  logic        rstMode = 1'b0;
  logic [3:0]  entrySel = '0;
  logic [1:0]  wordSel = '0;
  logic [15:0] rdWord;

  always #2 clk = ~clk;

  rx_cam_filter u_dut (.*);

  int checkCnt = 0, failCnt = 0;
  int hsCnt = 0, waitCnt = 0;
  logic [31:0] logAddr [128];
  logic [47:0] expTbl [16];
  logic [15:0] expMask = '0;

  function automatic logic [15:0] memWord(input logic [31:0] a);
    return {a[7:0], a[15:8]} ^ a[31:16] ^ 16'h3C5A;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder with per-request latency 0..2 cycles
  initial begin
    forever begin
      @(negedge clk);
      if (memValid) begin
        memValid = 1'b0;
        waitCnt  = 0;
      end else if (memReq) begin
        if (waitCnt >= hsCnt % 3) begin
          memRdata = memWord(memAddr);
          memValid = 1'b1;
          if (hsCnt < 128) logAddr[hsCnt] = memAddr;
          hsCnt++;
        end else begin
          waitCnt++;
        end
      end
    end
  end

  task automatic doLoad(input logic [15:0] seg, input logic [15:0] ptr,
                        input logic [15:0] cnt, input logic wide, input bit inject);
    logic [31:0] expA [128];
    int n, nExp, desc, st;
    bit addrOk;
    n = int'(cnt[4:0]);
    desc = wide ? 16 : 8;
    st = wide ? 4 : 2;
    nExp = 0;
    for (int i = 0; i < n; i++) begin
      for (int k = 1; k <= 3; k++) begin
        logic [31:0] a;
        a = {seg, 16'(int'(ptr) + i * desc + k * st)};
        expA[nExp] = a;
        nExp++;
        expTbl[i % 16][16*(k-1) +: 16] = memWord(a);
      end
    end
    expA[nExp] = {seg, 16'(int'(ptr) + n * desc)};
    expMask = memWord(expA[nExp]);
    nExp++;
    // clear done flag first (R5)
    @(negedge clk); doneClr = 1'b1;
    @(negedge clk); doneClr = 1'b0;
    check(loadDone == 1'b0, "R5 doneClr clears flag", 64'(loadDone), 64'd0);
    hsCnt = 0;
    segBase = seg; descPtr = ptr; descCnt = cnt; wideBus = wide; loadCmd = 1'b1;
    @(negedge clk); loadCmd = 1'b0;
    check(loadBusy == 1'b1, "R11 busy after command", 64'(loadBusy), 64'd1);
    if (inject) begin
      repeat (3) @(negedge clk);
      segBase = 16'hFFFF; descPtr = 16'h4444; descCnt = 16'h0002; wideBus = ~wide;
      loadCmd = 1'b1;
      @(negedge clk); loadCmd = 1'b0;
    end
    while (!loadDone) @(negedge clk);
    check(loadBusy == 1'b0, "R5 busy low at done", 64'(loadBusy), 64'd0);
    check(hsCnt == nExp, inject ? "R12 read count" : "R4 read count",
          64'(hsCnt), 64'(nExp));
    addrOk = 1'b1;
    for (int i = 0; i < nExp && i < hsCnt; i++)
      if (logAddr[i] !== expA[i]) begin
        addrOk = 1'b0;
        $display("FAIL R3 address %0d actual=%0h expected=%0h", i, logAddr[i], expA[i]);
      end
    check(addrOk, wide ? "R3 wide addresses" : "R11 narrow addresses",
          64'(addrOk), 64'd1);
    repeat (2) @(negedge clk);
    check(loadDone == 1'b1, "R5 done sticky", 64'(loadDone), 64'd1);
  endtask

  task automatic checkTable(input string tag);
    rstMode = 1'b1;
    for (int e = 0; e < 16; e++) begin
      for (int w = 0; w < 3; w++) begin
        entrySel = 4'(e); wordSel = 2'(w);
        #1;
        check(rdWord == expTbl[e][16*w +: 16], tag, 64'(rdWord),
              64'(expTbl[e][16*w +: 16]));
      end
    end
    wordSel = 2'd3; #1;
    check(rdWord == 16'h0, "R10 field 3 reads zero", 64'(rdWord), 64'd0);
    rstMode = 1'b0; wordSel = 2'd0; #1;
    check(rdWord == 16'h0, "R10 readback gated off", 64'(rdWord), 64'd0);
  endtask

  task automatic checkFilt(input logic [47:0] d, input logic p, input logic m,
                           input logic b);
    bit pr, mc, bc, cam, eAcc, eMc, eBc;
    string tag;
    dstAddr = d; modePromisc = p; modeAllMulti = m; modeBcast = b;
    #1;
    pr = p && !d[0];
    mc = m && d[0];
    bc = b && (d == 48'hFFFF_FFFF_FFFF);
    cam = 1'b0;
    for (int j = 0; j < 16; j++) if (expMask[j] && expTbl[j] == d) cam = 1'b1;
    eAcc = pr || mc || bc || cam;
    eMc = !pr && mc;
    eBc = !pr && !mc && bc;
    if (pr) tag = "R6 promiscuous";
    else if (mc) tag = "R7 all-group";
    else if (bc) tag = "R8 broadcast";
    else if (cam) tag = "R1 table match";
    else tag = "R9 reject";
    check({accept, isMcast, isBcast} == {eAcc, eMc, eBc}, tag,
          64'({accept, isMcast, isBcast}), 64'({eAcc, eMc, eBc}));
  endtask

  task automatic sweep();
    for (int mode = 0; mode < 8; mode++) begin
      for (int e = 0; e < 16; e++) begin
        checkFilt(expTbl[e], mode[0], mode[1], mode[2]);
        checkFilt(expTbl[e] ^ 48'h0100_0000_0000, mode[0], mode[1], mode[2]);
      end
      checkFilt(48'hFFFF_FFFF_FFFF, mode[0], mode[1], mode[2]);
      checkFilt(48'h0000_0000_0000, mode[0], mode[1], mode[2]);
      checkFilt(48'h5544_3322_1102, mode[0], mode[1], mode[2]);
      checkFilt(48'h5544_3322_1101, mode[0], mode[1], mode[2]);
    end
    modePromisc = 1'b0; modeAllMulti = 1'b0; modeBcast = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL R11 watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    for (int e = 0; e < 16; e++) expTbl[e] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check(loadBusy == 0 && loadDone == 0 && memReq == 0, "R5 reset idle",
          64'({loadBusy, loadDone, memReq}), 64'd0);
    checkFilt(48'h0, 1'b0, 1'b0, 1'b0);
    checkTable("R10 reset table zero");

    // full narrow load, 16 descriptors
    doLoad(16'h0012, 16'h0100, 16'h0010, 1'b0, 1'b0);
    checkTable("R2 narrow readback");
    sweep();

    // wide stride, 5 descriptors
    doLoad(16'h0034, 16'h2000, 16'h0005, 1'b1, 1'b0);
    checkTable("R3 wide readback");
    sweep();

    // count with low bits zero: only the mask read
    doLoad(16'h0056, 16'h3000, 16'h0020, 1'b0, 1'b0);
    checkTable("R4 zero count keeps table");
    sweep();

    // 19 descriptors wrap onto entries 0..2
    doLoad(16'h0078, 16'h4F00, 16'h0013, 1'b0, 1'b0);
    checkTable("R4 wrap readback");
    sweep();

    // command injected mid-load is ignored
    doLoad(16'h009A, 16'h6000, 16'h0003, 1'b1, 1'b1);
    checkTable("R12 readback after injection");
    sweep();

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule